// File: doc/BRIEF.md
# Bus Cycle Wait-State Controller

This block steps a processor bus access through its clock states. An access starts with T1, T2 and T3. Zero or more wait states follow, and the access ends with T4. It is used for accesses that fall inside a chip-select region. When a cycle starts, the region's configuration is captured. That configuration gives a 3-bit wait code, which maps to a non-linear set of internal wait counts, and a flag that says whether an external ready signal must also be honoured.

The internal wait count is always used up first. When ready is required, the ready input is sampled once at the first wait state. If it is high there, the cycle ends after the programmed waits. If it is low, the controller keeps waiting until ready is seen, and then adds a fixed tail of two further wait states before T4. With a zero wait code and ready required, the sample is taken in T3 instead. A bypass input makes the access behave as an internal register access: no waits, and ready is ignored. The same input serves selects whose wait logic is switched off.

Top module: `bus_wait_ctrl`

## Requirements
- R1: The wait code maps to an internal wait count. With wait_code[2] clear, wait_code[1:0] gives 0, 1, 2 or 3 waits. With wait_code[2] set, wait_code[1:0] = 0, 1, 2, 3 gives 5, 7, 9 and 15 waits.
- R2: bus_state is encoded as 0 idle, 1 T1, 2 T2, 3 T3, 4 wait, 5 T4. A cyc_start seen at a clock edge while idle puts the block in T1 after that edge. T2, T3, any waits and then T4 follow, one state per clock, and the block returns to idle after T4.
- R3: When rdy_req is low, the access has exactly the coded number of waits, so it takes 4 + N clocks (19 clocks for code 7), whatever ext_rdy does.
- R4: When rdy_req is high, N is not zero and ext_rdy is high at the first wait state, the access has exactly N waits (7 clocks for code 3).
- R5: When rdy_req is high, N is not zero and ext_rdy is low at the first wait state, let j be the first later wait state at which ext_rdy is high. The access then has max(N, j + 2) waits.
- R6: When rdy_req is high and N is zero, ext_rdy is sampled in T3. If it is high, no wait state occurs. If it is low, let j be the first wait state with ext_rdy high; the access then has j + 2 waits.
- R7: While cfg_bypass is high at the start, the access has zero waits and ignores ext_rdy, whatever the code and rdy_req are.
- R8: cyc_done is high for exactly the one clock spent in T4. A cyc_start that arrives while an access is in progress, including during T4, is ignored, and the block stays idle afterwards.
- R9: wait_active is high exactly in the clocks where bus_state is the wait state.
- R10: The configuration inputs are captured at the start. Changing them during an access does not change that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start | input | 1 | Request to begin an access (taken only when idle) |
| wait_code | input | 3 | Region wait code (bit 2 selects the extended set) |
| rdy_req | input | 1 | Region requires external ready |
| cfg_bypass | input | 1 | Treat as zero-wait access without ready |
| ext_rdy | input | 1 | External ready, already synchronised |
| bus_state | output | 3 | Current bus state (encoding in R2) |
| wait_active | output | 1 | High during wait states |
| cyc_done | output | 1 | One-clock pulse in T4 |

## Verification
The hardest case to reach from the ports is the late-ready tail: ready is missed at the first-wait sample and only arrives partway through the programmed count. That case is the only one where max(N, j + 2) picks between its two terms. The bench drives ext_rdy as a level that rises at a chosen wait index, counted from the bus_state it observes. This places the ready edge both before and after the end of the programmed waits. Zero-wait ready sampling in T3 is reached the same way, with the rise index set to the T3 slot or to a later wait.

// File: rtl/bus_wait_pkg.sv
// Shared types for the bus wait-state controller.
// Assumes: state encoding is visible at the top port and is relied on by users.
package bus_wait_pkg;

    typedef enum logic [2:0] {
        BS_IDLE = 3'd0,
        BS_T1   = 3'd1,
        BS_T2   = 3'd2,
        BS_T3   = 3'd3,
        BS_TW   = 3'd4,
        BS_T4   = 3'd5
    } bus_state_e;

    typedef enum logic [1:0] {
        RDY_OK     = 2'd0,
        RDY_SAMPLE = 2'd1,
        RDY_POLL   = 2'd2,
        RDY_TAIL   = 2'd3
    } rdy_state_e;

endpackage

// File: rtl/ws_code_decode.sv
// Wait-code decoder: turns the 3-bit region code into an internal wait count.
// Assumes: code[2] picks the extended set {5,7,9,15}; otherwise code[1:0] is the count.
module ws_code_decode #(
    parameter int CODE_W = 3,
    parameter int CNT_W  = 4
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  count
);
    localparam int SEL_W = CODE_W - 1;

    logic [SEL_W-1:0] sel;
    assign sel = code[SEL_W-1:0];

    // Map the low selector into either the linear or the extended count set.
    always_comb begin
        if (!code[CODE_W-1]) begin
            count = CNT_W'(sel);
        end else begin
            case (sel)
                2'd0:    count = CNT_W'(5);
                2'd1:    count = CNT_W'(7);
                2'd2:    count = CNT_W'(9);
                default: count = CNT_W'(15);
            endcase
        end
    end
endmodule

// File: rtl/ws_ready_track.sv
// External-ready tracker: resolves whether ready lets the current wait state end.
// Assumes: armed during T3 of each access; ext_rdy is already synchronous.
// A missed first sample leads to polling; a late ready adds TAIL_WAITS waits.
module ws_ready_track
    import bus_wait_pkg::*;
#(
    parameter int TAIL_WAITS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic req,
    input  logic zero_waits,
    input  logic in_wait,
    input  logic ext_rdy,
    output logic rdy_done
);
    localparam int TAIL_W = $clog2(TAIL_WAITS + 1);

    rdy_state_e        rs_q;
    logic [TAIL_W-1:0] tail_q;

    // Decide whether the ready condition is met in this wait state.
    always_comb begin
        case (rs_q)
            RDY_OK:     rdy_done = 1'b1;
            RDY_SAMPLE: rdy_done = ext_rdy;
            RDY_POLL:   rdy_done = 1'b0;
            default:    rdy_done = (tail_q == TAIL_W'(1));
        endcase
    end

    // Advance the ready state: load at T3, then step once per wait state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_q   <= RDY_OK;
            tail_q <= '0;
        end else if (arm) begin
            if (!req)           rs_q <= RDY_OK;
            else if (zero_waits) rs_q <= RDY_POLL;
            else                rs_q <= RDY_SAMPLE;
            tail_q <= '0;
        end else if (in_wait) begin
            case (rs_q)
                RDY_SAMPLE: rs_q <= ext_rdy ? RDY_OK : RDY_POLL;
                RDY_POLL: begin
                    if (ext_rdy) begin
                        rs_q   <= RDY_TAIL;
                        tail_q <= TAIL_W'(TAIL_WAITS);
                    end
                end
                RDY_TAIL: begin
                    if (tail_q > TAIL_W'(1)) tail_q <= tail_q - TAIL_W'(1);
                    else                     rs_q   <= RDY_OK;
                end
                default: rs_q <= RDY_OK;
            endcase
        end
    end
endmodule

// File: rtl/ws_seq.sv
// Bus state sequencer: runs T1, T2, T3, waits and T4, and counts programmed waits.
// Assumes: configuration is valid at the start strobe; it is captured then.
module ws_seq
    import bus_wait_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] cfg_cnt,
    input  logic             cfg_req,
    input  logic             ext_rdy,
    input  logic             rdy_done,
    output bus_state_e       state,
    output logic             arm,
    output logic             req_q,
    output logic             zero_q,
    output logic             in_wait
);
    bus_state_e       state_q;
    bus_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] prog_q;
    logic             prog_last;

    assign state     = state_q;
    assign arm       = (state_q == BS_T3);
    assign in_wait   = (state_q == BS_TW);
    assign zero_q    = (cnt_q == '0);
    assign prog_last = (prog_q <= CNT_W'(1));

    // Next bus state from current state, the wait count and ready resolution.
    always_comb begin
        state_d = state_q;
        case (state_q)
            BS_IDLE: if (start) state_d = BS_T1;
            BS_T1:   state_d = BS_T2;
            BS_T2:   state_d = BS_T3;
            BS_T3: begin
                if (zero_q && (!req_q || ext_rdy)) state_d = BS_T4;
                else                               state_d = BS_TW;
            end
            BS_TW:   if (prog_last && rdy_done) state_d = BS_T4;
            BS_T4:   state_d = BS_IDLE;
            default: state_d = BS_IDLE;
        endcase
    end

    // Register the state, capture configuration at start, count programmed waits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BS_IDLE;
            cnt_q   <= '0;
            req_q   <= 1'b0;
            prog_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == BS_IDLE && start) begin
                cnt_q <= cfg_cnt;
                req_q <= cfg_req;
            end
            if (state_q == BS_T3)                       prog_q <= cnt_q;
            else if (state_q == BS_TW && prog_q != '0)  prog_q <= prog_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/bus_wait_ctrl.sv
// Bus cycle wait-state controller top: decodes the region code, applies bypass,
// and joins the sequencer with the external-ready tracker.
// Assumes: ext_rdy is synchronous to clk; address decode happens elsewhere.
module bus_wait_ctrl
    import bus_wait_pkg::*;
#(
    parameter int CODE_W     = 3,
    parameter int CNT_W      = 4,
    parameter int TAIL_WAITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic [CODE_W-1:0] wait_code,
    input  logic              rdy_req,
    input  logic              cfg_bypass,
    input  logic              ext_rdy,
    output logic [2:0]        bus_state,
    output logic              wait_active,
    output logic              cyc_done
);
    logic [CNT_W-1:0] dec_cnt;
    logic [CNT_W-1:0] eff_cnt;
    logic             eff_req;
    bus_state_e       st;
    logic             arm;
    logic             req_q;
    logic             zero_q;
    logic             in_wait;
    logic             rdy_done;

    ws_code_decode #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_dec (
        .code  (wait_code),
        .count (dec_cnt)
    );

    // Bypass forces a zero-wait access that does not need ready.
    always_comb begin
        eff_cnt = cfg_bypass ? '0 : dec_cnt;
        eff_req = cfg_bypass ? 1'b0 : rdy_req;
    end

    ws_seq #(.CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cyc_start),
        .cfg_cnt  (eff_cnt),
        .cfg_req  (eff_req),
        .ext_rdy  (ext_rdy),
        .rdy_done (rdy_done),
        .state    (st),
        .arm      (arm),
        .req_q    (req_q),
        .zero_q   (zero_q),
        .in_wait  (in_wait)
    );

    ws_ready_track #(.TAIL_WAITS(TAIL_WAITS)) u_rdy (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .req        (req_q),
        .zero_waits (zero_q),
        .in_wait    (in_wait),
        .ext_rdy    (ext_rdy),
        .rdy_done   (rdy_done)
    );

    assign bus_state   = st;
    assign wait_active = in_wait;
    assign cyc_done    = (st == BS_T4);
endmodule

// File: rtl/bus_wait_ctrl_chk.sv
// Protocol checker for the wait-state controller, bound to the top module.
// Assumes: observes only the top-level ports.
module bus_wait_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cyc_start,
    input logic [2:0] bus_state,
    input logic       wait_active,
    input logic       cyc_done
);
    // R2
    t1_to_t2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_state == 3'd1 |=> bus_state == 3'd2);
    // R2
    t2_to_t3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_state == 3'd2 |=> bus_state == 3'd3);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == 3'd0 && !cyc_start) |=> bus_state == 3'd0);
    // R2
    wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_state == 3'd4 |=> (bus_state == 3'd4 || bus_state == 3'd5));
    // R8
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> (bus_state == 3'd0 && !cyc_done));
    // R9
    wait_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wait_active) |-> $past(bus_state) == 3'd3);
endmodule

bind bus_wait_ctrl bus_wait_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_start   (cyc_start),
    .bus_state   (bus_state),
    .wait_active (wait_active),
    .cyc_done    (cyc_done)
);

// File: tb/bus_wait_ctrl_bench.sv
`timescale 1ns/1ps
module bus_wait_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_start = 1'b0;
    logic [2:0] wait_code = '0;
    logic       rdy_req = 1'b0;
    logic       cfg_bypass = 1'b0;
    logic       ext_rdy = 1'b0;
    logic [2:0] bus_state;
    logic       wait_active;
    logic       cyc_done;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    bus_wait_ctrl u_bus_wait_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_start   (cyc_start),
        .wait_code   (wait_code),
        .rdy_req     (rdy_req),
        .cfg_bypass  (cfg_bypass),
        .ext_rdy     (ext_rdy),
        .bus_state   (bus_state),
        .wait_active (wait_active),
        .cyc_done    (cyc_done)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Independent model of the code mapping and the ready rules.
    function automatic int code_waits(input int c);
        int ext[4] = '{5, 7, 9, 15};
        return (c >= 4) ? ext[c - 4] : c;
    endfunction

    function automatic int exp_waits(input int c, input bit rq, input bit byp, input int rf);
        int n = code_waits(c);
        if (byp) return 0;
        if (!rq) return n;
        if (n == 0) return (rf == 0) ? 0 : rf + 2;
        if (rf <= 1) return n;
        return (n > rf + 2) ? n : rf + 2;
    endfunction

    // One access. rf: ready rises at T3 (0) or at wait index rf. disturb: alter config and restart.
    task automatic run_cycle(input string req, input int c, input bit rq, input bit byp,
                             input int rf, input bit disturb);
        int ew = exp_waits(c, rq, byp, rf);
        int widx = 0;
        int nwait = 0;
        int nact = 0;
        int ndone = 0;
        int total = 0;
        int s;
        @(negedge clk);
        wait_code = 3'(c); rdy_req = rq; cfg_bypass = byp;
        cyc_start = 1'b1; ext_rdy = (rf == 0);
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            cyc_start = 1'b0;
            if (disturb) begin
                wait_code = 3'd7; rdy_req = 1'b1; cfg_bypass = 1'b0;
            end
            s = bus_state;
            if (k < 3) check({req, " R2 prefix"}, s, k + 1);
            if (s == 4) begin widx++; nwait++; end
            if (wait_active) nact++;
            if (cyc_done) begin
                ndone++;
                check({req, " R8 done in T4"}, s, 5);
            end
            ext_rdy = (rf == 0) || (s == 4 && widx >= rf);
            if (disturb && (k == 1 || s == 5)) cyc_start = 1'b1;
            total = k + 1;
            if (s == 5) break;
        end
        @(negedge clk);
        cyc_start = 1'b0;
        ext_rdy = 1'b0;
        check({req, " waits"}, nwait, ew);
        check({req, " clocks"}, total, ew + 4);
        check({req, " R9 wait_active"}, nact, nwait);
        check({req, " R8 done count"}, ndone, 1);
        check({req, " R2 idle after"}, bus_state, 0);
        @(negedge clk);
        check({req, " R8 stays idle"}, bus_state, 0);
        wait_code = '0; rdy_req = 1'b0; cfg_bypass = 1'b0;
    endtask

    task automatic t_reset;
        check("R2 reset state", bus_state, 0);
        check("R9 reset wait", wait_active, 0);
        check("R8 reset done", cyc_done, 0);
    endtask

    task automatic t_codes;
        for (int c = 0; c < 8; c++) run_cycle("R1 R3 code", c, 1'b0, 1'b0, 100, 1'b0);
        run_cycle("R3 rdy high ignored", 5, 1'b0, 1'b0, 0, 1'b0);
        run_cycle("R3 code7 19 clocks", 7, 1'b0, 1'b0, 100, 1'b0);
    endtask

    task automatic t_ready_first;
        run_cycle("R4 code3 7 clocks", 3, 1'b1, 1'b0, 1, 1'b0);
        run_cycle("R4 code4", 4, 1'b1, 1'b0, 0, 1'b0);
        run_cycle("R4 code7", 7, 1'b1, 1'b0, 1, 1'b0);
    endtask

    task automatic t_ready_late;
        run_cycle("R5 code3 j2", 3, 1'b1, 1'b0, 2, 1'b0);
        run_cycle("R5 code3 j5", 3, 1'b1, 1'b0, 5, 1'b0);
        run_cycle("R5 code6 j3", 6, 1'b1, 1'b0, 3, 1'b0);
        run_cycle("R5 code1 j4", 1, 1'b1, 1'b0, 4, 1'b0);
    endtask

    task automatic t_zero_ready;
        run_cycle("R6 ready in T3", 0, 1'b1, 1'b0, 0, 1'b0);
        run_cycle("R6 j1", 0, 1'b1, 1'b0, 1, 1'b0);
        run_cycle("R6 j3", 0, 1'b1, 1'b0, 3, 1'b0);
    endtask

    task automatic t_bypass;
        run_cycle("R7 bypass", 7, 1'b1, 1'b1, 100, 1'b0);
    endtask

    task automatic t_disturb;
        run_cycle("R10 R8 disturb", 2, 1'b0, 1'b0, 100, 1'b1);
    endtask

    initial begin
        #(200000 * 8);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_codes();
        t_ready_first();
        t_ready_late();
        t_zero_ready();
        t_bypass();
        t_disturb();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule